// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests from up to a few dozen sources and picks one to hand to a processor core. Each source has a two-bit priority field in a small register file. A zero field turns the source off. A nonzero field maps to an effective level inside the level window that the source is allowed to use. Each source's request line is captured into a pending bit on its rising edge. Among the pending, enabled sources, the block picks the winner and presents three things to the core: its vector number, its effective level and a vector address. A winner is flagged valid only when its level reaches the core's current mask.

The vector address is normally the vector base register joined with the vector number. Two fast slots can replace it. Each slot holds a vector number to compare against and a full-width address, and a winner that matches a slot takes that slot's address instead. While reset is held, the address output carries a fixed reset vector. Software sees the priority fields, the base, the fast slots, the pending bits and the presented level through a plain register read/write port. The core clears a pending bit by acknowledging its vector number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held, and right after it, `irq_addr` equals `RESET_VEC` (default 0x100000) and `irq_valid` is 0. Reset also sets every priority field and pending bit to 0, the vector base to 0, and both fast match registers to all ones (0x3F reads back), so no real source matches them.
- R2: A 0-to-1 change on `irq_req[s]` sets pending bit s. Pending bit s reads at address 16 + s/16, bit s%16, one clock after the edge.
- R3: An acknowledge with `ack_vec` = s clears pending bit s and leaves the other pending bits as they were. A request that stays high does not set the bit again. Writes to the pending addresses have no effect.
- R4: The priority field of source s sits at register address s/8, bits 2*(s%8)+1 down to 2*(s%8), and reads back as written. A source whose field is 00 is never presented, even when it is pending.
- R5: For a normal source, field values 01, 10 and 11 give levels 0, 1 and 2. For a source whose bit is set in `HIGH_WIN` (default sources 0 to 3), the same values give levels 1, 2 and 3.
- R6: Among pending, enabled sources, the highest level wins, and a tie goes to the lowest vector number.
- R7: `irq_valid` is 1 only when a winner exists and its level is greater than or equal to `core_mask`. A pending source below the mask is not presented.
- R8: When no fast slot matches, `irq_addr` is {vector base register bits 14:0 (address 8), vector number (6 bits)}.
- R9: Fast slot 0 is at addresses 9 (match number), 10 (address bits 15:0) and 11 (address bits 20:16). Fast slot 1 is at addresses 12, 13 and 14. A winner whose number equals a slot's match value gets that slot's 21-bit address, and slot 0 takes precedence over slot 1.
- R10: Address 20 reads {irq_valid, irq_level} in bits 2:0, which is the state presented to the core. Outputs follow the pending state one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Request lines, one per source |
| core_mask | input | 2 | Core's current interrupt mask level |
| ack_valid | input | 1 | Core acknowledges a vector |
| ack_vec | input | VEC_W | Vector number being acknowledged |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_data | output | 16 | Register read data (combinational) |
| irq_valid | output | 1 | A request is presented to the core |
| irq_level | output | 2 | Level of the presented request |
| irq_vec | output | VEC_W | Vector number of the presented request |
| irq_addr | output | ADDR_W | Vector address, or reset vector during reset |

## Verification
The bench targets four groups of corner cases. The first is ties at the same level, including a high-window source at level 1 against a normal source at level 1; a wrong tie-break would present the higher-numbered vector. The second is the mask boundary, where level equal to the mask must pass and level 0 under a mask of 1 must not; an off-by-one compare would present the masked source or drop the equal one. The third is a disabled but pending source, which a wrong decode would present. It also covers a request held high after acknowledge, which level capture would make pending again. The fourth is a vector that matches both fast slots, where reversed slot precedence would return the second slot's address.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int REG_AW = 5;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] A_VBASE    = 5'd8;
    localparam logic [REG_AW-1:0] A_F0_MATCH = 5'd9;
    localparam logic [REG_AW-1:0] A_F0_LO    = 5'd10;
    localparam logic [REG_AW-1:0] A_F0_HI    = 5'd11;
    localparam logic [REG_AW-1:0] A_F1_MATCH = 5'd12;
    localparam logic [REG_AW-1:0] A_F1_LO    = 5'd13;
    localparam logic [REG_AW-1:0] A_F1_HI    = 5'd14;
    localparam logic [REG_AW-1:0] A_PEND0    = 5'd16;
    localparam logic [REG_AW-1:0] A_STATUS   = 5'd20;

    // Map a nonzero 2-bit field to its effective level inside the source window
    function automatic logic [1:0] eff_level(input logic [1:0] fld, input logic hi_win);
        return hi_win ? fld : (fld - 2'd1);
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 46,
    parameter int VEC_W   = 6,
    parameter int ADDR_W  = 21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [REG_DW-1:0]     wr_data,
    output logic [REG_DW-1:0]     rd_data,
    input  logic [NUM_SRC-1:0]    pend,
    input  logic [2:0]            stat,
    output logic [2*NUM_SRC-1:0]  prio_flat,
    output logic [ADDR_W-VEC_W-1:0] vbase,
    output logic [VEC_W-1:0]      fm0,
    output logic [VEC_W-1:0]      fm1,
    output logic [ADDR_W-1:0]     fa0,
    output logic [ADDR_W-1:0]     fa1
);
    localparam int PRIO_REGS = (NUM_SRC + 7) / 8;
    localparam int PEND_REGS = (NUM_SRC + 15) / 16;
    localparam int BASE_W    = ADDR_W - VEC_W;
    localparam int FHI_W     = ADDR_W - REG_DW;

    typedef struct packed {
        logic [2*NUM_SRC-1:0] prio;
        logic [BASE_W-1:0]    vbase;
        logic [VEC_W-1:0]     fm0;
        logic [VEC_W-1:0]     fm1;
        logic [ADDR_W-1:0]    fa0;
        logic [ADDR_W-1:0]    fa1;
    } regs_t;

    regs_t q, d;
    logic [16*PRIO_REGS-1:0] prio_pad;
    logic [16*PEND_REGS-1:0] pend_pad;

    always_comb begin
        d = q;
        if (wr_en) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (addr == REG_AW'(s / 8))
                    d.prio[2*s +: 2] = wr_data[2*(s%8) +: 2];
            end
            case (addr)
                A_VBASE:    d.vbase = wr_data[BASE_W-1:0];
                A_F0_MATCH: d.fm0 = wr_data[VEC_W-1:0];
                A_F0_LO:    d.fa0[REG_DW-1:0] = wr_data;
                A_F0_HI:    d.fa0[ADDR_W-1:REG_DW] = wr_data[FHI_W-1:0];
                A_F1_MATCH: d.fm1 = wr_data[VEC_W-1:0];
                A_F1_LO:    d.fa1[REG_DW-1:0] = wr_data;
                A_F1_HI:    d.fa1[ADDR_W-1:REG_DW] = wr_data[FHI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prio  <= '0;
            q.vbase <= '0;
            q.fm0   <= '1;
            q.fm1   <= '1;
            q.fa0   <= '0;
            q.fa1   <= '0;
        end else begin
            q <= d;
        end
    end

    assign prio_pad = (16*PRIO_REGS)'(q.prio);
    assign pend_pad = (16*PEND_REGS)'(pend);

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < PRIO_REGS; r++) begin
            if (addr == REG_AW'(r)) rd_data = prio_pad[16*r +: 16];
        end
        for (int r = 0; r < PEND_REGS; r++) begin
            if (addr == A_PEND0 + REG_AW'(r)) rd_data = pend_pad[16*r +: 16];
        end
        case (addr)
            A_VBASE:    rd_data = REG_DW'(q.vbase);
            A_F0_MATCH: rd_data = REG_DW'(q.fm0);
            A_F0_LO:    rd_data = q.fa0[REG_DW-1:0];
            A_F0_HI:    rd_data = REG_DW'(q.fa0[ADDR_W-1:REG_DW]);
            A_F1_MATCH: rd_data = REG_DW'(q.fm1);
            A_F1_LO:    rd_data = q.fa1[REG_DW-1:0];
            A_F1_HI:    rd_data = REG_DW'(q.fa1[ADDR_W-1:REG_DW]);
            A_STATUS:   rd_data = REG_DW'(stat);
            default: ;
        endcase
    end

    assign prio_flat = q.prio;
    assign vbase     = q.vbase;
    assign fm0       = q.fm0;
    assign fm1       = q.fm1;
    assign fa0       = q.fa0;
    assign fa1       = q.fa1;
endmodule

// File: rtl/pic_pending.sv
module pic_pending #(
    parameter int NUM_SRC = 46,
    parameter int VEC_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_vec,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] req_prev
);
    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic [NUM_SRC-1:0] pend;
    } pend_t;

    pend_t q, d;
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        clr    = ack_valid ? (NUM_SRC'(1) << ack_vec) : '0;
        d.req  = req;
        d.pend = (q.pend & ~clr) | (req & ~q.req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend     = q.pend;
    assign req_prev = q.req;
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int                 NUM_SRC  = 46,
    parameter int                 VEC_W    = 6,
    parameter logic [NUM_SRC-1:0] HIGH_WIN = '0
) (
    input  logic [NUM_SRC-1:0]   pend,
    input  logic [2*NUM_SRC-1:0] prio_flat,
    output logic                 found,
    output logic [VEC_W-1:0]     win_vec,
    output logic [1:0]           win_lvl
);
    always_comb begin
        logic [1:0] fld;
        logic [1:0] lvl;
        found   = 1'b0;
        win_vec = '0;
        win_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            fld = prio_flat[2*i +: 2];
            lvl = eff_level(fld, HIGH_WIN[i]);
            // strict compare keeps the lowest index on a tie
            if (pend[i] && (fld != 2'b00) && (!found || (lvl > win_lvl))) begin
                found   = 1'b1;
                win_lvl = lvl;
                win_vec = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int                  NUM_SRC   = 46,
    parameter int                  ADDR_W    = 21,
    parameter logic [NUM_SRC-1:0]  HIGH_WIN  = NUM_SRC'(4'hF),
    parameter logic [ADDR_W-1:0]   RESET_VEC = ADDR_W'(21'h100000),
    localparam int                 VEC_W     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [1:0]         core_mask,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_vec,
    input  logic               reg_wr_en,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [REG_DW-1:0]  reg_wr_data,
    output logic [REG_DW-1:0]  reg_rd_data,
    output logic               irq_valid,
    output logic [1:0]         irq_level,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [ADDR_W-1:0]  irq_addr
);
    localparam int BASE_W = ADDR_W - VEC_W;

    typedef struct packed {
        logic              valid;
        logic [1:0]        lvl;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t q, d;

    logic [NUM_SRC-1:0]   pend_vec;
    logic [NUM_SRC-1:0]   req_prev;
    logic [2*NUM_SRC-1:0] prio_flat;
    logic [BASE_W-1:0]    vbase;
    logic [VEC_W-1:0]     fm0, fm1;
    logic [ADDR_W-1:0]    fa0, fa1;
    logic                 found;
    logic [VEC_W-1:0]     win_vec;
    logic [1:0]           win_lvl;

    pic_pending #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req),
        .ack_valid(ack_valid), .ack_vec(ack_vec),
        .pend(pend_vec), .req_prev(req_prev)
    );

    pic_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wr_data(reg_wr_data), .rd_data(reg_rd_data),
        .pend(pend_vec), .stat({q.valid, q.lvl}),
        .prio_flat(prio_flat), .vbase(vbase),
        .fm0(fm0), .fm1(fm1), .fa0(fa0), .fa1(fa1)
    );

    pic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .HIGH_WIN(HIGH_WIN)) u_arb (
        .pend(pend_vec), .prio_flat(prio_flat),
        .found(found), .win_vec(win_vec), .win_lvl(win_lvl)
    );

    always_comb begin
        d       = q;
        d.valid = found && (win_lvl >= core_mask);
        if (found) begin
            d.lvl = win_lvl;
            d.vec = win_vec;
            if (win_vec == fm0)      d.addr = fa0;
            else if (win_vec == fm1) d.addr = fa1;
            else                     d.addr = {vbase, win_vec};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.valid <= 1'b0;
            q.lvl   <= '0;
            q.vec   <= '0;
            q.addr  <= RESET_VEC;
        end else begin
            q <= d;
        end
    end

    assign irq_valid = q.valid;
    assign irq_level = q.lvl;
    assign irq_vec   = q.vec;
    assign irq_addr  = q.addr;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int                 NUM_SRC   = 46,
    parameter int                 ADDR_W    = 21,
    parameter logic [NUM_SRC-1:0] HIGH_WIN  = '0,
    parameter logic [ADDR_W-1:0]  RESET_VEC = '0,
    localparam int                VEC_W     = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [1:0]         core_mask,
    input logic               ack_valid,
    input logic [VEC_W-1:0]   ack_vec,
    input logic               irq_valid,
    input logic [1:0]         irq_level,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [ADDR_W-1:0]  irq_addr,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] req_q
);
    localparam logic [2**VEC_W-1:0] HW_PAD = (2**VEC_W)'(HIGH_WIN);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_vec_chk: assert (irq_addr == RESET_VEC && !irq_valid);
        end
    end

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_req & ~req_q)) |=>
        ((pend_q & $past(irq_req & ~req_q)) == $past(irq_req & ~req_q)));

    // R3
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (ack_vec < VEC_W'(NUM_SRC)) && !(irq_req[ack_vec] && !req_q[ack_vec]))
        |=> !pend_q[$past(ack_vec)]);

    // R7
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level >= $past(core_mask)));

    // R5
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !HW_PAD[irq_vec]) |-> (irq_level != 2'd3));
endmodule

bind prio_irq_ctrl pic_checker #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .HIGH_WIN(HIGH_WIN), .RESET_VEC(RESET_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_vec(irq_vec), .irq_addr(irq_addr),
    .pend_q(pend_vec), .req_q(req_prev)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int NS = 46;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [NS-1:0] irq_req = '0;
    logic [1:0]    core_mask = '0;
    logic          ack_valid = 1'b0;
    logic [VW-1:0] ack_vec = '0;
    logic          reg_wr_en = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [15:0]   reg_wr_data = '0;
    logic [15:0]   reg_rd_data;
    logic          irq_valid;
    logic [1:0]    irq_level;
    logic [VW-1:0] irq_vec;
    logic [20:0]   irq_addr;

    int total = 0;
    int bad   = 0;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .irq_valid(irq_valid), .irq_level(irq_level), .irq_vec(irq_vec),
        .irq_addr(irq_addr)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [NS-1:0] req;
        logic [1:0]    mask;
        logic          ev;
        logic [VW-1:0] vec;
        logic [1:0]    lvl;
        logic [3:0]    rq;
    } row_t;

    localparam row_t ROWS [12] = '{
        '{46'h000000000400, 2'd0, 1'b1, 6'd10, 2'd2, 4'd8},  // R8 normal address
        '{46'h000000001400, 2'd0, 1'b1, 6'd10, 2'd2, 4'd6},  // R6 tie at level 2
        '{46'h200000001000, 2'd0, 1'b1, 6'd12, 2'd2, 4'd9},  // R9 fast slot 0
        '{46'h000040100000, 2'd0, 1'b1, 6'd20, 2'd1, 4'd9},  // R9 fast slot 1
        '{46'h000040000000, 2'd0, 1'b1, 6'd30, 2'd0, 4'd5},  // R5 field 01 -> level 0
        '{46'h000040000000, 2'd1, 1'b0, 6'd0,  2'd0, 4'd7},  // R7 below mask
        '{46'h200000000001, 2'd3, 1'b1, 6'd0,  2'd3, 4'd5},  // R5 high window level 3
        '{46'h000000100002, 2'd0, 1'b1, 6'd1,  2'd1, 4'd6},  // R6 tie across windows
        '{46'h000000000020, 2'd0, 1'b0, 6'd0,  2'd0, 4'd4},  // R4 disabled source
        '{46'h200000000020, 2'd2, 1'b1, 6'd45, 2'd2, 4'd7},  // R7 level equals mask
        '{46'h000000000402, 2'd2, 1'b1, 6'd10, 2'd2, 4'd6},  // R6 higher level wins
        '{46'h200000000000, 2'd3, 1'b0, 6'd0,  2'd0, 4'd7}   // R7 masked
    };

    function automatic logic [20:0] exp_addr(input logic [VW-1:0] v);
        if (v == 6'd12)      return {5'h15, 16'hBEEF};
        else if (v == 6'd20) return {5'h0A, 16'h0123};
        else                 return {15'h1234, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = v;
        tick(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic ack(input int s);
        ack_valid = 1'b1; ack_vec = VW'(s);
        tick(1);
        ack_valid = 1'b0;
    endtask

    initial begin
        #700000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        #1 rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(irq_valid == 1'b0, "R1", 32'(irq_valid), 0);
        chk(irq_addr == 21'h100000, "R1", 32'(irq_addr), 32'h100000);
        rd(5'd0, v);  chk(v == 16'h0, "R1", 32'(v), 0);
        rd(5'd9, v);  chk(v == 16'h3F, "R1", 32'(v), 32'h3F);
        rd(5'd16, v); chk(v == 16'h0, "R1", 32'(v), 0);

        // configuration
        wr(5'd0, 16'h0007);
        wr(5'd1, 16'h0330);
        wr(5'd2, 16'h0200);
        wr(5'd3, 16'h1000);
        wr(5'd5, 16'h0C00);
        wr(5'd8, 16'h1234);
        wr(5'd9, 16'd12);  wr(5'd10, 16'hBEEF); wr(5'd11, 16'h0015);
        wr(5'd12, 16'd20); wr(5'd13, 16'h0123); wr(5'd14, 16'h000A);
        // R4 field placement readback
        rd(5'd1, v); chk(v == 16'h0330, "R4", 32'(v), 32'h0330);
        rd(5'd5, v); chk(v == 16'h0C00, "R4", 32'(v), 32'h0C00);

        // R2 edge capture, pending bit 40 at address 18 bit 8
        irq_req[40] = 1'b1;
        tick(1);
        rd(5'd18, v); chk(v == 16'h0100, "R2", 32'(v), 32'h0100);
        // R3 ack with request still high stays clear
        ack(40);
        tick(2);
        rd(5'd18, v); chk(v == 16'h0000, "R3", 32'(v), 0);
        irq_req[40] = 1'b0;
        // R3 pending registers ignore writes
        irq_req[3] = 1'b1;
        tick(1);
        wr(5'd16, 16'hFFFF);
        rd(5'd16, v); chk(v == 16'h0008, "R3", 32'(v), 32'h0008);
        irq_req[3] = 1'b0;
        ack(3);
        tick(2);

        // table of vectors
        for (int i = 0; i < 12; i++) begin
            string tg;
            tg = $sformatf("R%0d row %0d", ROWS[i].rq, i);
            irq_req   = ROWS[i].req;
            core_mask = ROWS[i].mask;
            tick(2);
            chk(irq_valid == ROWS[i].ev, tg, 32'(irq_valid), 32'(ROWS[i].ev));
            if (ROWS[i].ev) begin
                chk(irq_vec == ROWS[i].vec, tg, 32'(irq_vec), 32'(ROWS[i].vec));
                chk(irq_level == ROWS[i].lvl, tg, 32'(irq_level), 32'(ROWS[i].lvl));
                chk(irq_addr == exp_addr(ROWS[i].vec), tg, 32'(irq_addr), 32'(exp_addr(ROWS[i].vec)));
            end
            irq_req = '0;
            for (int s = 0; s < NS; s++) begin
                if (ROWS[i].req[s]) ack(s);
            end
            tick(2);
            // R3 everything acknowledged
            chk(irq_valid == 1'b0, "R3 after acks", 32'(irq_valid), 0);
        end

        // R10 status register and one-cycle follow of mask change (R7)
        core_mask = 2'd0;
        irq_req[10] = 1'b1;
        tick(2);
        rd(5'd20, v); chk(v == 16'h0006, "R10", 32'(v), 32'h6);
        core_mask = 2'd3;
        tick(1);
        chk(irq_valid == 1'b0, "R7", 32'(irq_valid), 0);
        rd(5'd20, v); chk(v == 16'h0002, "R10", 32'(v), 32'h2);
        core_mask = 2'd0;
        irq_req[10] = 1'b0;
        ack(10);
        tick(2);

        // R9 both slots match: slot 0 wins
        wr(5'd12, 16'd12);
        irq_req[12] = 1'b1;
        tick(2);
        chk(irq_addr == 21'h15BEEF, "R9", 32'(irq_addr), 32'h15BEEF);
        irq_req[12] = 1'b0;
        ack(12);
        wr(5'd12, 16'd20);
        tick(2);

        // R1 reset in mid-run
        irq_req[10] = 1'b1;
        tick(2);
        chk(irq_valid == 1'b1, "R1 pre", 32'(irq_valid), 1);
        rst_n = 1'b0;
        #1;
        chk(irq_addr == 21'h100000, "R1", 32'(irq_addr), 32'h100000);
        chk(irq_valid == 1'b0, "R1", 32'(irq_valid), 0);
        irq_req = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        rd(5'd1, v); chk(v == 16'h0, "R1", 32'(v), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule